// File: doc/BRIEF.md
# Serial DAC Write Controller

This block feeds a write-only serial digital-to-analog converter. A parallel sample arrives on a valid/ready handshake and is captured into a shift register. The block lowers an active-low chip select, clocks the word out most significant bit first on a serial data line, and toggles a serial clock derived from the system clock. The serial clock idles low. Data changes on its falling edges, so the converter can sample on the rising edges.

Once the frame closes, an active-low load strobe moves the shifted word into the converter output. A mode input chooses when this happens: either automatically after every frame, or only when a load request arrives. A separate clear request produces an active-low clear pulse. A clear request that arrives while a frame is active waits until that frame, and its load strobe, have finished.

Every minimum interval is a parameter counted in system clock cycles: serial clock half period, select setup, select hold, select gap, select-to-load delay, load width and clear width. The user sets each one by rounding the converter's nanosecond limit up to whole clock periods. Word width is also a parameter (16 by default, 12 for the narrower part).

Top module: `dac_serial_writer`

## Requirements
- R1: Each accepted word is sent as exactly DATA_W bits on `sdo`, most significant bit first, with one bit per rising edge of `sck`, and words leave in the order they were accepted.
- R2: `sck` stays high for HALF_CYC cycles and low for HALF_CYC cycles between its rising edges, and it is low whenever `sel_n` is high.
- R3: While `sel_n` is low, `sdo` changes only in the cycle where `sck` falls or where `sel_n` falls, so it is stable across every rising edge of `sck`.
- R4: The first rising edge of `sck` comes exactly CS_SETUP_CYC+HALF_CYC cycles after `sel_n` falls. `sel_n` rises exactly HALF_CYC+CS_HOLD_CYC cycles after the last rising edge of `sck`.
- R5: Between two frames, `sel_n` stays high for at least CS_GAP_CYC+1 cycles.
- R6: With `auto_load`=1, `load_n` falls exactly CS_GAP_CYC+LD_SETUP_CYC cycles after `sel_n` rises and stays low for LD_WIDTH_CYC cycles.
- R7: With `auto_load`=0, a frame produces no `load_n` pulse. A `load_req` pulse produces one `load_n` pulse of LD_WIDTH_CYC cycles. With `auto_load`=1, `load_req` is ignored.
- R8: A `clr_req` pulse produces one `clr_out_n` pulse of CLR_WIDTH_CYC cycles. `clr_out_n` is never low while `sel_n` or `load_n` is low, so a request made during a frame is deferred.
- R9: After reset, `sel_n`, `load_n` and `clr_out_n` are high, `sck` is low and `in_ready` is high. `in_ready` is high only when no frame, load strobe or clear pulse is active or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DATA_W | Sample to send |
| auto_load | input | 1 | 1: strobe load after each frame; 0: only on request |
| load_req | input | 1 | One-cycle explicit load request |
| clr_req | input | 1 | One-cycle clear request |
| sck | output | 1 | Serial clock to converter |
| sel_n | output | 1 | Active-low chip select |
| sdo | output | 1 | Serial data to converter |
| load_n | output | 1 | Active-low load strobe |
| clr_out_n | output | 1 | Active-low clear pulse |

## Verification
The words 8001, 0000, FFFF, A5C3 and 1234 are sent back to back:
- 8001 separates the first bit from the last, so a reversed or off-by-one shift shows up.
- The all-zero and all-one words catch a stuck data line.
- The mixed words catch a wrong shift order.
- Sending them back to back exercises the minimum select gap.

The same words in request-driven load mode separate automatic strobes from requested ones. A load request in automatic mode shows that it is ignored. A clear request made in the middle of a frame shows whether the clear is deferred or overlaps the frame.

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
  parameter int DATA_W        = 16,
  parameter int HALF_CYC      = 1,
  parameter int CS_SETUP_CYC  = 1,
  parameter int CS_HOLD_CYC   = 1,
  parameter int CS_GAP_CYC    = 1,
  parameter int LD_SETUP_CYC  = 1,
  parameter int LD_WIDTH_CYC  = 1,
  parameter int CLR_WIDTH_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              auto_load,
  input  logic              load_req,
  input  logic              clr_req,
  output logic              sck,
  output logic              sel_n,
  output logic              sdo,
  output logic              load_n,
  output logic              clr_out_n
);

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAXC = imax(imax(imax(HALF_CYC, CS_SETUP_CYC), imax(CS_HOLD_CYC, CS_GAP_CYC)),
                             imax(imax(LD_SETUP_CYC, LD_WIDTH_CYC), CLR_WIDTH_CYC));
  localparam int CW = $clog2(MAXC + 1);
  localparam int BW = $clog2(DATA_W);
  localparam logic [CW-1:0] C_HALF = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0] C_SET  = CW'(CS_SETUP_CYC - 1);
  localparam logic [CW-1:0] C_HOLD = CW'(CS_HOLD_CYC - 1);
  localparam logic [CW-1:0] C_GAP  = CW'(CS_GAP_CYC - 1);
  localparam logic [CW-1:0] C_LDS  = CW'(LD_SETUP_CYC - 1);
  localparam logic [CW-1:0] C_LDW  = CW'(LD_WIDTH_CYC - 1);
  localparam logic [CW-1:0] C_CLR  = CW'(CLR_WIDTH_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_LOW, S_HIGH, S_HOLD, S_GAP, S_LDSET, S_LOAD, S_CLR
  } state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bits;
  logic [DATA_W-1:0] sh;
  logic              clr_pend, ld_pend;
  logic              in_frame;

  assign in_frame  = (st == S_SETUP) || (st == S_LOW) || (st == S_HIGH) || (st == S_HOLD);
  assign sel_n     = !in_frame;
  assign sck       = (st == S_HIGH);
  assign sdo       = in_frame ? sh[DATA_W-1] : 1'b0;
  assign load_n    = (st != S_LOAD);
  assign clr_out_n = (st != S_CLR);
  assign in_ready  = (st == S_IDLE) && !clr_pend && !ld_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bits     <= '0;
      sh       <= '0;
      clr_pend <= 1'b0;
      ld_pend  <= 1'b0;
    end else begin
      if (clr_req) clr_pend <= 1'b1;
      if (load_req && !auto_load) ld_pend <= 1'b1;
      if (st == S_IDLE) begin
        if (clr_pend) begin
          st       <= S_CLR;
          cnt      <= C_CLR;
          clr_pend <= 1'b0;
        end else if (ld_pend) begin
          st      <= S_LDSET;
          cnt     <= C_LDS;
          ld_pend <= 1'b0;
        end else if (in_valid) begin
          st   <= S_SETUP;
          cnt  <= C_SET;
          sh   <= in_data;
          bits <= LAST_BIT;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_SETUP: begin st <= S_LOW; cnt <= C_HALF; end
          S_LOW:   begin st <= S_HIGH; cnt <= C_HALF; end
          S_HIGH: begin
            if (bits == '0) begin
              st  <= S_HOLD;
              cnt <= C_HOLD;
            end else begin
              st   <= S_LOW;
              cnt  <= C_HALF;
              bits <= bits - 1'b1;
              sh   <= {sh[DATA_W-2:0], 1'b0};
            end
          end
          S_HOLD:  begin st <= S_GAP; cnt <= C_GAP; end
          S_GAP: begin
            if (auto_load) begin
              st  <= S_LDSET;
              cnt <= C_LDS;
            end else begin
              st <= S_IDLE;
            end
          end
          S_LDSET: begin st <= S_LOAD; cnt <= C_LDW; end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) sel_n |-> !sck); // R2
  AST_SDO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !$fell(sel_n) && !$fell(sck)) |-> $stable(sdo)); // R3
  AST_LOAD_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n) !load_n |-> sel_n); // R6
  AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_out_n |-> (sel_n && load_n)); // R8
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (sel_n && load_n && clr_out_n)); // R9
  AST_ACCEPT_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !sel_n); // R9

endmodule

// File: tb/dac_serial_writer_tb.sv
module dac_serial_writer_tb;
  localparam int DW = 16, H = 2, CSS = 2, CSH = 3, GAP = 2, LDS = 3, LDW = 4, CLRW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, auto_load = 1'b1, load_req = 1'b0, clr_req = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, sck, sel_n, sdo, load_n, clr_out_n;

  always #10 clk = ~clk;

  dac_serial_writer #(.DATA_W(DW), .HALF_CYC(H), .CS_SETUP_CYC(CSS), .CS_HOLD_CYC(CSH),
    .CS_GAP_CYC(GAP), .LD_SETUP_CYC(LDS), .LD_WIDTH_CYC(LDW), .CLR_WIDTH_CYC(CLRW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .auto_load(auto_load), .load_req(load_req), .clr_req(clr_req), .sck(sck), .sel_n(sel_n),
    .sdo(sdo), .load_n(load_n), .clr_out_n(clr_out_n));

  int checks = 0, errors = 0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] w);
    @(negedge clk);
    exp_q.push_back(w);
    in_data = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_req = 1'b1;
    @(negedge clk); clr_req = 1'b0;
  endtask

  // monitor state
  logic p_sel = 1'b1, p_sck = 1'b0, p_ld = 1'b1, p_clr = 1'b1, p_sdo = 1'b0;
  int t_fall = 0, t_rise_sck = 0, t_rise_sel = 0;
  int run_sel = 0, run_sck = 0, run_ld = 0, run_clr = 0;
  int nbits = 0, n_ld = 0, n_clr = 0;
  logic seen_frame = 1'b0, exp_auto_ld = 1'b0;
  logic [DW-1:0] got = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      t_fall++; t_rise_sck++; t_rise_sel++;
      if (sel_n && sck) chk(1'b0, "R2 sck high while sel_n high", 1, 0);
      if (!sel_n && !p_sel && sdo != p_sdo && !(p_sck && !sck)) chk(1'b0, "R3 sdo moved off sck fall", sdo, p_sdo);
      if (!p_sck && sck) begin
        if (nbits == 0) chk(t_fall == CSS + H, "R4 select setup", t_fall, CSS + H);
        else chk(run_sck == H, "R2 sck low time", run_sck, H);
        got = {got[DW-2:0], sdo};
        nbits++;
        t_rise_sck = 0;
      end
      if (p_sck && !sck) chk(run_sck == H, "R2 sck high time", run_sck, H);
      if (p_sel && !sel_n) begin
        if (seen_frame) chk(run_sel >= GAP + 1, "R5 select gap", run_sel, GAP + 1);
        nbits = 0;
        t_fall = 0;
      end
      if (!p_sel && sel_n) begin
        logic [DW-1:0] e;
        seen_frame = 1'b1;
        chk(t_rise_sck == H + CSH, "R4 select hold", t_rise_sck, H + CSH);
        chk(nbits == DW, "R1 bit count", nbits, DW);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        chk(got == e, "R1 word", got, e);
        t_rise_sel = 0;
        exp_auto_ld = auto_load;
      end
      if (p_ld && !load_n) begin
        n_ld++;
        if (exp_auto_ld) chk(t_rise_sel == GAP + LDS, "R6 load delay", t_rise_sel, GAP + LDS);
        exp_auto_ld = 1'b0;
      end
      if (!p_ld && load_n) chk(run_ld == LDW, "R6 R7 load width", run_ld, LDW);
      if (p_clr && !clr_out_n) n_clr++;
      if (!p_clr && clr_out_n) chk(run_clr == CLRW, "R8 clear width", run_clr, CLRW);
      if (!clr_out_n && (!sel_n || !load_n)) chk(1'b0, "R8 clear overlaps", 1, 0);
      if (in_ready && (!sel_n || !load_n || !clr_out_n)) chk(1'b0, "R9 ready while busy", 1, 0);
      run_sel = (sel_n == p_sel) ? run_sel + 1 : 1;
      run_sck = (sck == p_sck) ? run_sck + 1 : 1;
      run_ld  = (load_n == p_ld) ? run_ld + 1 : 1;
      run_clr = (clr_out_n == p_clr) ? run_clr + 1 : 1;
      p_sel = sel_n; p_sck = sck; p_ld = load_n; p_clr = clr_out_n; p_sdo = sdo;
    end
  end

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ld0;
    repeat (3) @(negedge clk);
    chk(sel_n && load_n && clr_out_n && !sck, "R9 reset outputs", {sel_n, load_n, clr_out_n, sck}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R9 ready after reset", in_ready, 1);

    auto_load = 1'b1;
    send(16'h8001); send(16'h0000); send(16'hFFFF); send(16'hA5C3); send(16'h1234);
    wait_idle();
    chk(n_ld == 5, "R6 one load per frame", n_ld, 5);
    chk(exp_q.size() == 0, "R1 all words sent", exp_q.size(), 0);

    ld0 = n_ld;
    pulse_load();
    repeat (20) @(negedge clk);
    chk(n_ld == ld0, "R7 load_req ignored in auto mode", n_ld, ld0);

    auto_load = 1'b0;
    send(16'h5A5A); send(16'hC001);
    wait_idle();
    chk(n_ld == ld0, "R7 no load in manual mode", n_ld, ld0);
    pulse_load();
    wait_idle();
    chk(n_ld == ld0 + 1, "R7 requested load", n_ld, ld0 + 1);

    pulse_clr();
    wait_idle();
    chk(n_clr == 1, "R8 idle clear", n_clr, 1);

    auto_load = 1'b1;
    send(16'h0F0F);
    repeat (5) @(negedge clk);
    chk(!sel_n, "R8 frame active at clear request", sel_n, 0);
    pulse_clr();
    chk(n_clr == 1, "R8 clear deferred during frame", n_clr, 1);
    wait_idle();
    chk(n_clr == 2, "R8 deferred clear issued", n_clr, 2);
    chk(n_ld == ld0 + 2, "R6 load before deferred clear", n_ld, ld0 + 2);
    chk(exp_q.size() == 0, "R1 queue drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule